// File: doc/BRIEF.md
# Iterative Floating-Point Mantissa Divider

This block divides two floating-point operands that have already been unpacked into a class code, a sign, a signed unbiased exponent and a normalized mantissa in [1,2). It returns an unpacked quotient: a class code, a sign, a widened signed exponent, a mantissa with two extra low-order bits (guard and round), and a sticky bit. It also reports the invalid-operation and divide-by-zero exceptions. Packing, rounding and exponent range checks belong to the logic around it.

Operands with a special class (NaN, infinity, zero) are resolved in the cycle that accepts them, following a fixed priority. Two finite nonzero operands start a restoring shift-subtract loop that produces one quotient bit per clock. The first trial subtraction picks the exponent and seeds the remainder, so the quotient never needs a normalizing shift afterwards. A start/busy/done handshake controls the block. Results stay on the outputs until the next accepted operation.

Class codes used on all class ports: 0 zero, 1 finite nonzero, 2 infinity, 3 quiet NaN, 4 signalling NaN. With FRAC_W fraction bits in, the internal mantissa width is MW = FRAC_W+3. The MSB of the output mantissa is the integer bit and its two LSBs are guard and round.

Top module: `fdiv_unit`

## Requirements
- R1: For two operands of class 1, the result class is 1. With X and Y the input mantissas extended by two zero bits, the result mantissa is floor(X·2^(MW-1)/Y) when X ≥ Y, and floor(2X·2^(MW-1)/Y) otherwise. Its MSB is therefore always 1.
- R2: For two operands of class 1, the result exponent is ea−eb when X ≥ Y and ea−eb−1 otherwise. It is given as an EXP_W+1-bit two's-complement value.
- R3: For two operands of class 1, the sticky bit is 1 exactly when the remainder of the division in R1 is nonzero.
- R4: In every result that is not a NaN, the sign is the XOR of the two operand signs.
- R5: If either operand is a NaN (class 3 or 4), the result is one of the operands. If only one operand is a NaN, that operand is chosen. If both are NaNs and exactly one of them is signalling, the signalling one is chosen. In every other two-NaN case the divisor is chosen. The result carries the chosen operand's class, sign and mantissa, followed by two zero bits. The exponent is 0 and no flag is raised.
- R6: Infinity/infinity and zero/zero give the default NaN: class 3, sign 0, mantissa with its two top bits set and all other bits clear, exponent 0. The invalid flag is raised.
- R7: A dividend of infinity or zero over a divisor of a different non-NaN class gives a result of the dividend's class, with mantissa 0 and exponent 0.
- R8: A finite nonzero dividend over infinity gives class 0. Over zero it gives class 2 and raises the divide-by-zero flag. Mantissa and exponent are 0 in both cases.
- R9: A special case raises done in the cycle after its start edge, and busy stays low. For a normal divide, busy is high from the cycle after the start edge. Done rises after the (MW+1)-th clock edge, counting the start edge as the first.
- R10: start has no effect while busy is high. The operation in flight keeps its operands and result, and no extra done is produced.
- R11: done is a one-cycle pulse. All result outputs and flags hold their values until the next accepted operation.
- R12: A synchronous active-low reset clears busy, done and every result output and flag to zero, including in the middle of a divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when busy is low) |
| a_cls | input | 3 | Dividend class code |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | EXP_W | Dividend exponent, two's complement |
| a_mant | input | FRAC_W+1 | Dividend mantissa, integer bit at MSB |
| b_cls | input | 3 | Divisor class code |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | EXP_W | Divisor exponent, two's complement |
| b_mant | input | FRAC_W+1 | Divisor mantissa, integer bit at MSB |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| q_cls | output | 3 | Result class code |
| q_sign | output | 1 | Result sign |
| q_exp | output | EXP_W+1 | Result exponent, two's complement |
| q_mant | output | FRAC_W+3 | Result mantissa with guard and round bits |
| q_sticky | output | 1 | OR of the final remainder |
| flg_invalid | output | 1 | Invalid-operation exception |
| flg_divzero | output | 1 | Divide-by-zero exception |

## Verification
A wrong remainder or a wrong quotient-bit decision in the loop shows up at the ports. It changes a mantissa bit at and below the position where it happens, or it changes the sticky bit. It surfaces only when done rises, MW+1 edges after start, so the bench compares every field against an integer-division model at that moment. A wrong choice on the first trial subtraction shows at once as an exponent off by one and a quotient with a clear MSB. A counter or handshake fault shows as a done that arrives early, late or twice. A special-case priority fault shows as a wrong class or flag in the cycle after start.

// File: rtl/fdiv_pkg.sv
// Shared definitions for the floating-point divider.
// Assumes the class code is carried on 3-bit ports.
package fdiv_pkg;
    typedef enum logic [2:0] {
        FC_ZERO = 3'd0,
        FC_NUM  = 3'd1,
        FC_INF  = 3'd2,
        FC_QNAN = 3'd3,
        FC_SNAN = 3'd4
    } fclass_e;
endpackage

// File: rtl/fdiv_special.sv
// Special-operand resolver (combinational).
// Takes the operand classes and signs and decides whether the quotient
// follows without iteration, and if so what it is. Checks run in this
// order: NaN, then dividend inf/zero, then divisor inf, then divisor zero.
// Assumes the mantissas are normalized whenever the class is finite.
module fdiv_special
    import fdiv_pkg::*;
#(
    parameter int FRAC_W = 7,
    localparam int MW = FRAC_W + 3
) (
    input  logic [2:0]        x_cls,
    input  logic              x_sign,
    input  logic [FRAC_W:0]   x_mant,
    input  logic [2:0]        y_cls,
    input  logic              y_sign,
    input  logic [FRAC_W:0]   y_mant,
    output logic              is_special,
    output logic [2:0]        r_cls,
    output logic              r_sign,
    output logic [MW-1:0]     r_mant,
    output logic              r_inv,
    output logic              r_dz
);
    logic x_nan, y_nan, x_snan, y_snan, pick_x;

    assign x_nan  = (x_cls == FC_QNAN) || (x_cls == FC_SNAN);
    assign y_nan  = (y_cls == FC_QNAN) || (y_cls == FC_SNAN);
    assign x_snan = (x_cls == FC_SNAN);
    assign y_snan = (y_cls == FC_SNAN);
    // The dividend is chosen only when it alone is NaN, or alone signalling.
    assign pick_x = x_nan && (!y_nan || (x_snan && !y_snan));

    // Apply the special-case priority chain.
    always_comb begin
        is_special = 1'b1;
        r_cls      = FC_ZERO;
        r_sign     = x_sign ^ y_sign;
        r_mant     = '0;
        r_inv      = 1'b0;
        r_dz       = 1'b0;
        if (x_nan || y_nan) begin
            r_cls  = pick_x ? x_cls  : y_cls;
            r_sign = pick_x ? x_sign : y_sign;
            r_mant = pick_x ? {x_mant, 2'b00} : {y_mant, 2'b00};
        end else if ((x_cls == FC_INF) || (x_cls == FC_ZERO)) begin
            if (x_cls == y_cls) begin
                r_cls  = FC_QNAN;
                r_sign = 1'b0;
                r_mant = {2'b11, {(MW-2){1'b0}}};
                r_inv  = 1'b1;
            end else begin
                r_cls = x_cls;
            end
        end else if (y_cls == FC_INF) begin
            r_cls = FC_ZERO;
        end else if (y_cls == FC_ZERO) begin
            r_cls = FC_INF;
            r_dz  = 1'b1;
        end else begin
            is_special = 1'b0;
            r_cls      = FC_NUM;
        end
    end
endmodule

// File: rtl/fdiv_mant_core.sv
// Restoring mantissa divider, one quotient bit per clock.
// On load it makes the trial subtraction X-Y. If that is non-negative the
// remainder becomes X-Y, otherwise it becomes 2X-Y. Either way the quotient
// MSB is 1 and lead_ge records which exponent applies. MW-1 iterations then
// produce the remaining bits, and fin pulses once the last one is stored.
// Assumes both mantissas lie in [1,2) with the integer bit at MSB, and that
// load is raised only while busy is low.
module fdiv_mant_core #(
    parameter int MW = 10,
    localparam int RW = MW + 1,
    localparam int CW = $clog2(MW) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [MW-1:0] x_mant,
    input  logic [MW-1:0] y_mant,
    output logic          busy,
    output logic          fin,
    output logic          lead_ge,
    output logic [MW-1:0] quo,
    output logic          sticky
);
    logic [RW-1:0] rem_r;
    logic [MW-1:0] div_r;
    logic [MW-1:0] q_r;
    logic [CW-1:0] cnt_r;
    logic [RW:0]   d_first;
    logic [RW-1:0] seed_rem;
    logic          first_ge;
    logic [RW-1:0] sh_rem;
    logic [RW:0]   d_iter;
    logic          take;

    // First trial subtraction chooses the remainder seed.
    always_comb begin
        d_first  = {2'b00, x_mant} - {2'b00, y_mant};
        first_ge = ~d_first[RW];
        seed_rem = first_ge ? d_first[RW-1:0] : ({x_mant, 1'b0} - {1'b0, y_mant});
    end

    // Shift and trial-subtract for one iteration.
    always_comb begin
        sh_rem = {rem_r[RW-2:0], 1'b0};
        d_iter = {1'b0, sh_rem} - {2'b00, div_r};
        take   = ~d_iter[RW];
    end

    // Sequence the loop and keep the partial quotient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r   <= '0;
            div_r   <= '0;
            q_r     <= '0;
            cnt_r   <= '0;
            busy    <= 1'b0;
            fin     <= 1'b0;
            lead_ge <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                rem_r   <= seed_rem;
                div_r   <= y_mant;
                q_r     <= {1'b1, {(MW-1){1'b0}}};
                cnt_r   <= CW'(MW - 1);
                busy    <= 1'b1;
                lead_ge <= first_ge;
            end else if (busy) begin
                rem_r <= take ? d_iter[RW-1:0] : sh_rem;
                q_r[CW'(cnt_r - 1'b1)] <= take;
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CW'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

    assign quo    = q_r;
    assign sticky = |rem_r;

    // R1: the remainder stays below the divisor, so the shift cannot overflow.
    a_r1_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem_r < {1'b0, div_r}));
    // R10: the controller never reloads an operation that is in flight.
    a_r10_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
endmodule

// File: rtl/fdiv_unit.sv
// Floating-point divider on unpacked operands (top).
// A special operand pair is resolved in the accepting cycle. A finite pair
// starts the mantissa core, and the result is captured when it finishes.
// The exponent difference is held from the start and corrected by one when
// the dividend mantissa is the smaller.
// Assumes finite operands carry normalized mantissas. Rounding and exponent
// range handling are done downstream.
module fdiv_unit
    import fdiv_pkg::*;
#(
    parameter int FRAC_W = 7,
    parameter int EXP_W  = 8,
    localparam int MW  = FRAC_W + 3,
    localparam int OEW = EXP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        a_cls,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [FRAC_W:0]   a_mant,
    input  logic [2:0]        b_cls,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [FRAC_W:0]   b_mant,
    output logic              busy,
    output logic              done,
    output logic [2:0]        q_cls,
    output logic              q_sign,
    output logic [OEW-1:0]    q_exp,
    output logic [MW-1:0]     q_mant,
    output logic              q_sticky,
    output logic              flg_invalid,
    output logic              flg_divzero
);
    logic          sp_hit, sp_sign, sp_inv, sp_dz;
    logic [2:0]    sp_cls;
    logic [MW-1:0] sp_mant;
    logic          core_busy, core_fin, core_ge, core_sticky;
    logic [MW-1:0] core_quo;
    logic          accept, load;
    logic          sign_r;
    logic [OEW-1:0] ediff_r;

    fdiv_special #(.FRAC_W(FRAC_W)) u_special (
        .x_cls(a_cls), .x_sign(a_sign), .x_mant(a_mant),
        .y_cls(b_cls), .y_sign(b_sign), .y_mant(b_mant),
        .is_special(sp_hit), .r_cls(sp_cls), .r_sign(sp_sign),
        .r_mant(sp_mant), .r_inv(sp_inv), .r_dz(sp_dz)
    );

    fdiv_mant_core #(.MW(MW)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load),
        .x_mant({a_mant, 2'b00}), .y_mant({b_mant, 2'b00}),
        .busy(core_busy), .fin(core_fin), .lead_ge(core_ge),
        .quo(core_quo), .sticky(core_sticky)
    );

    assign busy   = core_busy | core_fin;
    assign accept = start & ~busy;
    assign load   = accept & ~sp_hit;

    // Capture the operation context, then publish results on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            q_cls       <= '0;
            q_sign      <= 1'b0;
            q_exp       <= '0;
            q_mant      <= '0;
            q_sticky    <= 1'b0;
            flg_invalid <= 1'b0;
            flg_divzero <= 1'b0;
            sign_r      <= 1'b0;
            ediff_r     <= '0;
        end else begin
            done <= 1'b0;
            if (accept && sp_hit) begin
                done        <= 1'b1;
                q_cls       <= sp_cls;
                q_sign      <= sp_sign;
                q_exp       <= '0;
                q_mant      <= sp_mant;
                q_sticky    <= 1'b0;
                flg_invalid <= sp_inv;
                flg_divzero <= sp_dz;
            end else if (load) begin
                sign_r  <= a_sign ^ b_sign;
                ediff_r <= OEW'($signed(a_exp)) - OEW'($signed(b_exp));
            end else if (core_fin) begin
                done        <= 1'b1;
                q_cls       <= FC_NUM;
                q_sign      <= sign_r;
                q_exp       <= ediff_r - OEW'(!core_ge);
                q_mant      <= core_quo;
                q_sticky    <= core_sticky;
                flg_invalid <= 1'b0;
                flg_divzero <= 1'b0;
            end
        end
    end

    // R9: a result is never published while an operation is still running.
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R1: a finite quotient always leaves with its integer bit set.
    a_r1_norm_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q_cls == FC_NUM) |-> q_mant[MW-1]);
    // R6: the invalid flag only accompanies a quiet NaN.
    a_r6_inv_is_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flg_invalid) |-> (q_cls == FC_QNAN));
    // R8: divide-by-zero only accompanies infinity, never with invalid.
    a_r8_dz_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flg_divzero) |-> (q_cls == FC_INF && !flg_invalid));
    // R11: results do not move while a divide is in flight.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(q_mant) && $stable(q_cls)));
endmodule

// File: tb/tb_fdiv_unit.sv
module tb_fdiv_unit;
    localparam int FW  = 7;
    localparam int EW  = 8;
    localparam int MW  = FW + 3;
    localparam int OEW = EW + 1;
    localparam int OPW = 3 + 1 + EW + FW + 1;
    localparam int NV  = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] a_cls = '0, b_cls = '0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic [EW-1:0] a_exp = '0, b_exp = '0;
    logic [FW:0] a_mant = '0, b_mant = '0;
    logic busy, done, q_sign, q_sticky, flg_invalid, flg_divzero;
    logic [2:0] q_cls;
    logic [OEW-1:0] q_exp;
    logic [MW-1:0] q_mant;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fdiv_unit #(.FRAC_W(FW), .EXP_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .busy(busy), .done(done), .q_cls(q_cls), .q_sign(q_sign),
        .q_exp(q_exp), .q_mant(q_mant), .q_sticky(q_sticky),
        .flg_invalid(flg_invalid), .flg_divzero(flg_divzero)
    );

    function automatic logic [2*OPW-1:0] mk(int ac, int as, int ae, int am,
                                           int bc, int bs, int be, int bm);
        return {3'(ac), 1'(as), EW'(ae), (FW+1)'(am),
                3'(bc), 1'(bs), EW'(be), (FW+1)'(bm)};
    endfunction

    // Stimulus table: dividend then divisor (class, sign, exp, mant).
    localparam logic [2*OPW-1:0] VEC [NV] = '{
        mk(1,0,5,'h80,     1,0,2,'h80),    // R1 equal mantissas
        mk(1,1,0,'hC0,     1,0,0,'hA0),    // R1 X>Y, sign R4
        mk(1,0,3,'h80,     1,1,7,'hC0),    // R2 X<Y inexact
        mk(1,1,-4,'hFF,    1,1,9,'h81),    // R3 large ratio
        mk(1,0,10,'h81,    1,0,-10,'hFF),  // R2 X<Y near 0.5
        mk(1,0,-128,'h80,  1,1,127,'hFF),  // R2 exponent extreme
        mk(1,0,1,'hE0,     1,0,1,'hE0),    // R3 exact
        mk(3,1,0,'hA5,     1,0,0,'h80),    // R5 only dividend NaN
        mk(1,0,0,'h80,     4,1,0,'h99),    // R5 only divisor NaN
        mk(3,0,0,'hB1,     4,1,0,'hC3),    // R5 divisor signalling
        mk(4,1,0,'hD7,     3,0,0,'h8E),    // R5 dividend signalling
        mk(3,1,0,'hF0,     3,0,0,'h88),    // R5 both quiet -> divisor
        mk(2,0,0,0,        2,1,0,0),       // R6 inf/inf
        mk(0,1,0,0,        0,1,0,0),       // R6 0/0
        mk(2,1,0,0,        1,0,0,'h90),    // R7 inf/num
        mk(0,0,0,0,        2,1,0,0),       // R7 0/inf
        mk(1,1,0,'hC0,     2,0,0,0),       // R8 num/inf
        mk(1,0,0,'hC0,     0,1,0,0)        // R8 num/0
    };

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Independent reference built from the requirements.
    task automatic model(input logic [2*OPW-1:0] v,
                         output int ec, output int es, output int ee,
                         output longint em, output int est,
                         output int ei, output int ed, output string tag);
        logic [2:0] ac, bc;
        logic as, bs;
        logic [EW-1:0] ae, be;
        logic [FW:0] am, bm;
        longint x, y, num;
        bit an, bn, pa;
        {ac, as, ae, am, bc, bs, be, bm} = v;
        ec = 0; es = as ^ bs; ee = 0; em = 0; est = 0; ei = 0; ed = 0; tag = "R7";
        an = (ac == 3) || (ac == 4);
        bn = (bc == 3) || (bc == 4);
        if (an || bn) begin
            pa = an && (!bn || (ac == 4 && bc != 4));
            ec = pa ? ac : bc; es = pa ? as : bs;
            em = longint'(pa ? am : bm) << 2; tag = "R5";
        end else if (ac == 2 || ac == 0) begin
            if (ac == bc) begin
                ec = 3; es = 0; em = longint'(3) << (MW - 2); ei = 1; tag = "R6";
            end else ec = ac;
        end else if (bc == 2) begin
            ec = 0; tag = "R8";
        end else if (bc == 0) begin
            ec = 2; ed = 1; tag = "R8";
        end else begin
            x = longint'(am) << 2; y = longint'(bm) << 2;
            ee = $signed(ae) - $signed(be);
            if (x < y) begin x = 2 * x; ee = ee - 1; end
            num = x << (MW - 1);
            em = num / y; est = (num % y) != 0; ec = 1; tag = "R1";
        end
    endtask

    task automatic drive(input logic [2*OPW-1:0] v);
        {a_cls, a_sign, a_exp, a_mant, b_cls, b_sign, b_exp, b_mant} = v;
    endtask

    // Launch at a negedge; return at the negedge where done is seen.
    task automatic run_op(input logic [2*OPW-1:0] v, output int cyc, output bit busy1);
        drive(v);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        busy1 = busy;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic compare(input logic [2*OPW-1:0] v, input int cyc, input bit busy1);
        int ec, es, ee, est, ei, ed;
        longint em;
        string tag;
        model(v, ec, es, ee, em, est, ei, ed, tag);
        check(done == 1'b1, "R9", "done seen", done, 1);
        check(q_cls == 3'(ec), tag, "class", q_cls, ec);
        check(q_sign == 1'(es), (tag == "R5") ? "R5" : "R4", "sign", q_sign, es);
        check(q_mant == MW'(em), tag, "mantissa", q_mant, em);
        check($signed(q_exp) == ee, (ec == 1) ? "R2" : tag, "exponent", $signed(q_exp), ee);
        check(q_sticky == 1'(est), (ec == 1) ? "R3" : tag, "sticky", q_sticky, est);
        check(flg_invalid == 1'(ei), (tag == "R6") ? "R6" : tag, "invalid", flg_invalid, ei);
        check(flg_divzero == 1'(ed), (tag == "R8") ? "R8" : tag, "divzero", flg_divzero, ed);
        if (tag == "R1") begin
            check(cyc == MW + 1, "R9", "normal latency", cyc, MW + 1);
            check(busy1 == 1'b1, "R9", "busy after start", busy1, 1);
        end else begin
            check(cyc == 1, "R9", "special latency", cyc, 1);
            check(busy1 == 1'b0, "R9", "busy stays low", busy1, 0);
        end
    endtask

    // Watchdog: a hang counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cyc;
        bit b1;
        int ec, es, ee, est, ei, ed;
        longint em;
        string tag;
        logic [MW-1:0] held_m;

        repeat (3) @(negedge clk);
        // R12: reset state.
        check(busy == 0 && done == 0, "R12", "busy/done in reset", {busy, done}, 0);
        check(q_mant == 0 && q_cls == 0 && q_exp == 0, "R12", "results in reset", q_mant, 0);
        check(flg_invalid == 0 && flg_divzero == 0 && q_sticky == 0, "R12", "flags in reset",
              {flg_invalid, flg_divzero, q_sticky}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i], cyc, b1);
            compare(VEC[i], cyc, b1);
            @(negedge clk);
            check(done == 1'b0, "R11", "done is a pulse", done, 0);
        end

        // R10: start during busy with a special pair is ignored.
        drive(VEC[2]);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        drive(VEC[12]);
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R10", "no done from ignored start", done, 0);
        cyc = 3;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        model(VEC[2], ec, es, ee, em, est, ei, ed, tag);
        check(q_mant == MW'(em), "R10", "result of first op", q_mant, em);
        check(flg_invalid == 1'b0, "R10", "no invalid from ignored op", flg_invalid, 0);
        check(cyc == MW + 1, "R10", "latency kept", cyc, MW + 1);
        held_m = q_mant;
        drive(VEC[13]);
        repeat (3) @(negedge clk);
        // R11: outputs hold with no start and new operands present.
        check(done == 1'b0, "R11", "no extra done", done, 0);
        check(q_mant == held_m && q_cls == 3'd1, "R11", "result holds", q_mant, held_m);

        // R12: reset in mid-divide clears everything.
        drive(VEC[0]);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R12", "mid-run reset busy", busy, 0);
        check(q_mant == 0 && q_cls == 0, "R12", "mid-run reset result", q_mant, 0);
        rst_n = 1'b1;
        repeat (MW + 2) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R12", "aborted op stays dead", {busy, done}, 0);

        // R1: a fresh divide works after the abort.
        run_op(VEC[3], cyc, b1);
        compare(VEC[3], cyc, b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule